// File: doc/BRIEF.md
# Three-Phase LCD Drive Level Generator

This block produces the drive-level codes for a multiplexed liquid-crystal panel with three common lines and sixteen segment lines. A 48-bit display vector holds three bits per segment, one for each common phase. The block counts base-clock enables and walks each frame through six equal slots. The first three slots drive the commons in turn with positive polarity. The last three repeat that order with inverted polarity, so the panel sees no DC component. For every pin it outputs a 3-bit level code, and an external analog stage turns each code into a voltage.

At run time the controller picks a two-level-plus-midpoint (1/2) bias or a four-level (1/3) bias. It can also blank the panel. Blanking keeps the waveforms running but drives every segment with its off pattern. A sleep request and a system-reset flag both pull the panel low and restart the frame. A port-select field lets the first one to four segment pins act as plain logic outputs, each tied to a fixed display bit. These ports keep working in sleep, but the system reset forces them back to low segment outputs.

Top module: `lcd_wave_gen`

## Requirements
- R1: While `rst_n` is low, every common and segment level code is 0.
- R2: The frame counter advances only on cycles with `tick` high. One frame is 384 ticks, made of six 64-tick slots in this order: COM1, COM2, COM3 with positive polarity, then COM1, COM2, COM3 with inverted polarity.
- R3: Level codes are 0 = ground, 1 = 1/3, 2 = 1/2, 3 = 2/3 and 4 = full. The selected common drives 4 in a positive slot and 0 in an inverted slot. With `biasHalf`=1 the unselected commons drive 2. With `biasHalf`=0 they drive 1 in a positive slot and 3 in an inverted slot.
- R4: Segment n (0-based) in phase p (0-based) uses display bit `dispBits[3n+p]`. In a positive slot an on segment drives 0, and an off segment drives 4 with 1/2 bias or 3 with 1/3 bias. In an inverted slot an on segment drives 4, and an off segment drives 0 with 1/2 bias or 1 with 1/3 bias.
- R5: When `segBlank` is 1, every segment that is not acting as a port drives the off level of the current slot, whatever the display bits hold. The commons keep running.
- R6: While `sleepReq` or `sysReset` is high, all commons and all non-port segments drive 0 and the frame counter returns to the start of slot 0. The frame then restarts from COM1 positive when both are released.
- R7: The `portSel` values 0, 1, 2, 3 and 4 turn that many segment pins, starting from segment 0, into logic ports. Values 5 to 7 act as 4.
- R8: Port k (0-based) drives 4 when `dispBits[3k]` is 1 and 0 when it is 0. This holds in sleep too.
- R9: While `sysReset` is high, the port function is off and every segment pin, including the first four, drives 0.
- R10: Each output code reflects the inputs and frame position sampled at the previous rising clock edge, so there is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Base-clock enable, one pulse per oscillator period |
| dispBits | input | 48 | Display bits, three per segment |
| biasHalf | input | 1 | 1 selects 1/2 bias, 0 selects 1/3 bias |
| segBlank | input | 1 | 1 drives off waveforms on all segments |
| sleepReq | input | 1 | Sleep request, pulls the panel low |
| sysReset | input | 1 | System reset flag, pulls the panel and the ports low |
| portSel | input | 3 | Number of leading segment pins used as logic ports |
| comLevel | output | 9 | Level codes of the commons, COM1 in bits 2:0 |
| segLevel | output | 48 | Level codes of the segments, segment 0 in bits 2:0 |

## Verification
If the slot counter or the polarity flag holds a wrong value, the wrong common is selected or the polarity flips. That shows on `comLevel` within one clock of the bad state, because exactly one common must sit at an extreme code and that code must match the polarity. A wrong phase index makes segments read the wrong display bit, which shows on `segLevel` in the next cycle whenever the neighbouring bits differ. The reference model tracks the frame position independently and compares every pin on every clock, so a drifting slot length shows up at the first slot boundary that falls on the wrong tick.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

  localparam int LVL_W   = 3;
  localparam int PHASE_W = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_GND       = 3'd0,
    LVL_THIRD     = 3'd1,
    LVL_HALF      = 3'd2,
    LVL_TWO_THIRD = 3'd3,
    LVL_FULL      = 3'd4
  } level_e;

  // Strobes from frame control to the level datapath
  typedef struct packed {
    logic [PHASE_W-1:0] phase;   // active common index
    logic               invert;  // second half of frame
    logic               halted;  // sleep or system reset
    logic               rstHold; // system reset only
  } drv_strobe_t;

endpackage

// File: rtl/lcd_frame_ctrl.sv
module lcd_frame_ctrl
  import lcd_drv_pkg::*;
#(
  parameter int NUM_COM    = 3,
  parameter int SLOT_TICKS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        sleepReq,
  input  logic        sysReset,
  output drv_strobe_t strb
);

  localparam int CNT_W = $clog2(SLOT_TICKS);
  localparam logic [CNT_W-1:0]   LAST_TICK  = CNT_W'(SLOT_TICKS - 1);
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(NUM_COM - 1);

  logic [CNT_W-1:0]   tickCnt;
  logic [PHASE_W-1:0] phaseQ;
  logic               invQ;
  logic               haltNow;

  assign haltNow = sleepReq | sysReset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tickCnt <= '0;
      phaseQ  <= '0;
      invQ    <= 1'b0;
    end else if (haltNow) begin
      tickCnt <= '0;
      phaseQ  <= '0;
      invQ    <= 1'b0;
    end else if (tick) begin
      if (tickCnt == LAST_TICK) begin
        tickCnt <= '0;
        if (phaseQ == LAST_PHASE) begin
          phaseQ <= '0;
          invQ   <= ~invQ;
        end else begin
          phaseQ <= phaseQ + 1'b1;
        end
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.phase   = phaseQ;
    strb.invert  = invQ;
    strb.halted  = haltNow;
    strb.rstHold = sysReset;
  end

endmodule

// File: rtl/lcd_level_dp.sv
module lcd_level_dp
  import lcd_drv_pkg::*;
#(
  parameter int NUM_COM  = 3,
  parameter int NUM_SEG  = 16,
  parameter int NUM_PORT = 4,
  parameter int PSEL_W   = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  drv_strobe_t                 strb,
  input  logic [NUM_COM*NUM_SEG-1:0]  dispBits,
  input  logic                        biasHalf,
  input  logic                        segBlank,
  input  logic [PSEL_W-1:0]           portSel,
  output logic [NUM_COM*LVL_W-1:0]    comLevel,
  output logic [NUM_SEG*LVL_W-1:0]    segLevel
);

  localparam logic [PSEL_W-1:0] PORT_MAX = PSEL_W'(NUM_PORT);

  logic [PSEL_W-1:0] portCnt;
  logic [LVL_W-1:0]  comNext [NUM_COM];
  logic [LVL_W-1:0]  segNext [NUM_SEG];
  logic [LVL_W-1:0]  segOnLvl;
  logic [LVL_W-1:0]  segOffLvl;

  assign portCnt = (portSel > PORT_MAX) ? PORT_MAX : portSel;

  // Segment levels for the current polarity and bias
  always_comb begin
    if (strb.invert) begin
      segOnLvl  = LVL_FULL;
      segOffLvl = biasHalf ? LVL_GND : LVL_THIRD;
    end else begin
      segOnLvl  = LVL_GND;
      segOffLvl = biasHalf ? LVL_FULL : LVL_TWO_THIRD;
    end
  end

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    always_comb begin
      if (strb.halted) begin
        comNext[c] = LVL_GND;
      end else if (strb.phase == PHASE_W'(c)) begin
        comNext[c] = strb.invert ? LVL_GND : LVL_FULL;
      end else if (biasHalf) begin
        comNext[c] = LVL_HALF;
      end else begin
        comNext[c] = strb.invert ? LVL_TWO_THIRD : LVL_THIRD;
      end
    end
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic [NUM_COM-1:0] cellBits;
    logic               cellOn;
    logic [LVL_W-1:0]   waveLvl;
    assign cellBits = dispBits[s*NUM_COM +: NUM_COM];
    assign cellOn   = !segBlank && cellBits[strb.phase];
    assign waveLvl  = strb.halted ? LVL_GND : (cellOn ? segOnLvl : segOffLvl);

    if (s < NUM_PORT) begin : g_port
      logic portOn;
      assign portOn = (PSEL_W'(s) < portCnt) && !strb.rstHold;
      assign segNext[s] = portOn ? (cellBits[0] ? LVL_FULL : LVL_GND) : waveLvl;
    end else begin : g_plain
      assign segNext[s] = waveLvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comLevel <= '0;
      segLevel <= '0;
    end else begin
      for (int c = 0; c < NUM_COM; c++) comLevel[c*LVL_W +: LVL_W] <= comNext[c];
      for (int s = 0; s < NUM_SEG; s++) segLevel[s*LVL_W +: LVL_W] <= segNext[s];
    end
  end

endmodule

// File: rtl/lcd_wave_gen.sv
module lcd_wave_gen
  import lcd_drv_pkg::*;
#(
  parameter int NUM_COM    = 3,
  parameter int NUM_SEG    = 16,
  parameter int NUM_PORT   = 4,
  parameter int PSEL_W     = 3,
  parameter int SLOT_TICKS = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic [NUM_COM*NUM_SEG-1:0] dispBits,
  input  logic                       biasHalf,
  input  logic                       segBlank,
  input  logic                       sleepReq,
  input  logic                       sysReset,
  input  logic [PSEL_W-1:0]          portSel,
  output logic [NUM_COM*LVL_W-1:0]   comLevel,
  output logic [NUM_SEG*LVL_W-1:0]   segLevel
);

  drv_strobe_t strb;

  lcd_frame_ctrl #(
    .NUM_COM   (NUM_COM),
    .SLOT_TICKS(SLOT_TICKS)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .sleepReq(sleepReq),
    .sysReset(sysReset),
    .strb    (strb)
  );

  lcd_level_dp #(
    .NUM_COM (NUM_COM),
    .NUM_SEG (NUM_SEG),
    .NUM_PORT(NUM_PORT),
    .PSEL_W  (PSEL_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .dispBits(dispBits),
    .biasHalf(biasHalf),
    .segBlank(segBlank),
    .portSel (portSel),
    .comLevel(comLevel),
    .segLevel(segLevel)
  );

endmodule

// File: rtl/lcd_wave_gen_chk.sv
module lcd_wave_gen_chk #(
  parameter int NUM_COM  = 3,
  parameter int NUM_SEG  = 16,
  parameter int PSEL_W   = 3,
  parameter int LVL_W    = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_COM*NUM_SEG-1:0] dispBits,
  input logic                       biasHalf,
  input logic                       sleepReq,
  input logic                       sysReset,
  input logic [PSEL_W-1:0]          portSel,
  input logic [NUM_COM*LVL_W-1:0]   comLevel,
  input logic [NUM_SEG*LVL_W-1:0]   segLevel
);

  int  extremeCnt;
  int  thirdCnt;
  logic codesLegal;

  always_comb begin
    extremeCnt = 0;
    thirdCnt   = 0;
    codesLegal = 1'b1;
    for (int c = 0; c < NUM_COM; c++) begin
      if (comLevel[c*LVL_W +: LVL_W] == 3'd0 || comLevel[c*LVL_W +: LVL_W] == 3'd4)
        extremeCnt++;
      if (comLevel[c*LVL_W +: LVL_W] == 3'd1 || comLevel[c*LVL_W +: LVL_W] == 3'd3)
        thirdCnt++;
      if (comLevel[c*LVL_W +: LVL_W] > 3'd4) codesLegal = 1'b0;
    end
    for (int s = 0; s < NUM_SEG; s++)
      if (segLevel[s*LVL_W +: LVL_W] > 3'd4) codesLegal = 1'b0;
  end

  // R6
  halt_coms_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleepReq || sysReset) |=> (comLevel == '0));

  // R9
  reset_segs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sysReset |=> (segLevel == '0));

  // R8
  sleep_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleepReq && !sysReset && portSel != '0) |=>
      (segLevel[LVL_W-1:0] == ($past(dispBits[0]) ? 3'd4 : 3'd0)));

  // R3
  one_selected_com_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(sleepReq || sysReset)) |-> (extremeCnt == 1));

  // R3
  half_bias_no_third_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(biasHalf)) |-> (thirdCnt == 0));

  // R4
  legal_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    codesLegal);

endmodule

bind lcd_wave_gen lcd_wave_gen_chk #(
  .NUM_COM(NUM_COM),
  .NUM_SEG(NUM_SEG),
  .PSEL_W (PSEL_W),
  .LVL_W  (3)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .dispBits(dispBits),
  .biasHalf(biasHalf),
  .sleepReq(sleepReq),
  .sysReset(sysReset),
  .portSel (portSel),
  .comLevel(comLevel),
  .segLevel(segLevel)
);

// File: tb/tb_lcd_wave_gen.sv
`timescale 1ns/1ps
module tb_lcd_wave_gen;

  localparam int NC = 3;
  localparam int NS = 16;
  localparam int FRAME = 384;
  localparam int SLOT = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [47:0]   dispBits = '0;
  logic          biasHalf = 1'b0;
  logic          segBlank = 1'b0;
  logic          sleepReq = 1'b0;
  logic          sysReset = 1'b0;
  logic [2:0]    portSel = '0;
  logic [8:0]    comLevel;
  logic [47:0]   segLevel;

  always #10 clk = ~clk;

  lcd_wave_gen dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dispBits(dispBits),
    .biasHalf(biasHalf), .segBlank(segBlank), .sleepReq(sleepReq),
    .sysReset(sysReset), .portSel(portSel),
    .comLevel(comLevel), .segLevel(segLevel)
  );

  int vectors = 0;
  int fails = 0;
  bit finished = 0;
  string curReq = "R1";

  // Behavioural reference model
  int mCount = 0;
  int expCom [NC];
  int expSeg [NS];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mCount = 0;
      foreach (expCom[c]) expCom[c] = 0;
      foreach (expSeg[s]) expSeg[s] = 0;
    end else begin
      int slot, ph, ports;
      bit inv, halted, on;
      slot   = mCount / SLOT;
      ph     = slot % 3;
      inv    = (slot >= 3);
      halted = sleepReq || sysReset;
      ports  = (portSel > 4) ? 4 : int'(portSel);
      for (int c = 0; c < NC; c++) begin
        if (halted)        expCom[c] = 0;
        else if (c == ph)  expCom[c] = inv ? 0 : 4;
        else if (biasHalf) expCom[c] = 2;
        else               expCom[c] = inv ? 3 : 1;
      end
      for (int s = 0; s < NS; s++) begin
        on = !segBlank && dispBits[3*s + ph];
        if (halted)   expSeg[s] = 0;
        else if (inv) expSeg[s] = on ? 4 : (biasHalf ? 0 : 1);
        else          expSeg[s] = on ? 0 : (biasHalf ? 4 : 3);
        if (s < ports && !sysReset) expSeg[s] = dispBits[3*s] ? 4 : 0;
      end
      if (halted)    mCount = 0;
      else if (tick) mCount = (mCount + 1) % FRAME;
    end
  end

  task automatic compareOutputs();
    vectors++;
    for (int c = 0; c < NC; c++)
      if (int'(comLevel[c*3 +: 3]) != expCom[c]) begin
        fails++;
        $display("FAIL %s com%0d got %0d exp %0d at %0t", curReq, c,
                 comLevel[c*3 +: 3], expCom[c], $time);
      end
    for (int s = 0; s < NS; s++)
      if (int'(segLevel[s*3 +: 3]) != expSeg[s]) begin
        fails++;
        $display("FAIL %s seg%0d got %0d exp %0d at %0t", curReq, s,
                 segLevel[s*3 +: 3], expSeg[s], $time);
      end
  endtask

  task automatic runCycles(input int n, input int tickDiv, input int churnEvery);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareOutputs();
      tick = (tickDiv != 0) && (i % tickDiv == 0);
      if (churnEvery != 0 && (i % churnEvery == 0))
        dispBits = {16'($urandom()), $urandom()};
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    // R1: reset state
    curReq = "R1";
    dispBits = 48'hA5A5_5A5A_F00F;
    runCycles(4, 1, 0);
    rst_n = 1'b1;

    // R4: 1/3 bias segment mapping with varied data
    curReq = "R4";
    runCycles(900, 1, 97);

    // R2: slower tick, frame length and slot order
    curReq = "R2";
    runCycles(1400, 3, 211);

    // R3: 1/2 bias commons and segments
    curReq = "R3";
    biasHalf = 1'b1;
    runCycles(900, 1, 131);

    // R5: blanking in both biases
    curReq = "R5";
    segBlank = 1'b1;
    runCycles(400, 1, 50);
    biasHalf = 1'b0;
    runCycles(400, 1, 50);
    segBlank = 1'b0;

    // R6: sleep pulls low, frame restarts
    curReq = "R6";
    runCycles(100, 1, 0);
    sleepReq = 1'b1;
    runCycles(120, 1, 0);
    sleepReq = 1'b0;
    runCycles(500, 1, 0);

    // R7: every port-select value, including saturation
    curReq = "R7";
    for (int p = 0; p < 8; p++) begin
      portSel = 3'(p);
      runCycles(150, 1, 23);
    end

    // R8: ports stay live in sleep
    curReq = "R8";
    portSel = 3'd4;
    sleepReq = 1'b1;
    runCycles(200, 1, 7);
    sleepReq = 1'b0;
    runCycles(100, 1, 7);

    // R9: system reset overrides ports
    curReq = "R9";
    sysReset = 1'b1;
    runCycles(80, 1, 5);
    sysReset = 1'b0;
    runCycles(400, 1, 0);

    // R10: one-cycle latency with data changing every cycle
    curReq = "R10";
    portSel = 3'd2;
    runCycles(300, 1, 1);
    biasHalf = 1'b1;
    runCycles(300, 2, 1);

    summary();
  end

endmodule